// File: doc/BRIEF.md
# Hardware Cursor Overlay with Edge Clipping

This block holds a small ARGB cursor image in on-chip RAM and lays it over the outgoing RGB pixel stream at a screen position chosen by the host. The host asks for a signed position and a cursor size. The block clips that rectangle against the display size. It works out the on-screen origin, the visible width and height, and the offset into the bitmap where drawing starts. A cursor that hangs off the left or top edge therefore shows the correct part of its image.

A clipped request goes into shadow registers. It takes effect only on the next frame-done pulse, so no line of a frame that has already started changes part way through. A request that leaves nothing visible, or arrives while no image is loaded, switches the cursor off at once. Cursor pixels are loaded through a write port that advances its address on each write. The pixel stream passes through a two-stage pipeline. Where the cursor covers a pixel and the cursor pixel's alpha is non-zero, the cursor colour replaces the background. Every other pixel passes through unchanged.

Top module: `hwcur_top`

## Requirements
- R1: A request is accepted only if width and height are each between 1 and 64 and they are not both above 32. So 64x32 and 32x64 are the largest shapes, and 64x33, 33x33 and 65x1 are refused like an invisible request.
- R2: Each write stores one 32-bit ARGB word (alpha in bits 31:24, red in 23:16, green in 15:8, blue in 7:0) at a linear address. The address starts at 0 when the restart input is high and then rises by one per write. Addresses 256 and above fall in the second 256-word bank. The word is stored with red and blue exchanged. Reading it back undoes the exchange, so `out_rgb` carries red in bits 23:16, green in 15:8 and blue in 7:0.
- R3: A negative x gives screen x 0, a bitmap x offset of -x, and visible width w+x (0 if -x >= w). y is clipped the same way against h.
- R4: If x+w exceeds the display width, the visible width becomes display width minus x, with a floor of 0, and the bitmap offset is 0. The bottom edge uses the same rule with the display height.
- R5: With `interlaced` high, the visible height and screen y after clipping are both halved (integer division).
- R6: A request with zero visible width or height, a refused size, or `img_present` low drops `cur_on` on the clock edge that takes the request, and also cancels any pending update.
- R7: An accepted request changes `act_pos` ({screen y, screen x}, 16 bits each), `act_size` ({visible h, visible w}) and `cur_on` only on a clock edge with `frame_done` high. Until then they keep their old values.
- R8: The output is due two clock edges after a pixel is presented. Inside the active rectangle, a cursor word with non-zero alpha gives its RGB. Outside the rectangle, with the cursor off, or with alpha 0, the background passes through unchanged. `out_valid` follows `pix_valid` with the same delay.
- R9: The cursor word read for a screen pixel is at address (pix_y - screen y + y offset) * w + (pix_x - screen x + x offset), where w is the requested width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| px_wr_en | input | 1 | Write one cursor pixel word |
| px_wr_restart | input | 1 | Restart the write address at 0 for this write |
| px_wr_data | input | 32 | ARGB pixel word |
| img_present | input | 1 | A cursor image is loaded |
| upd_strobe | input | 1 | Take a new position/size request |
| req_x | input | 12 | Signed requested x |
| req_y | input | 12 | Signed requested y |
| req_w | input | 7 | Requested width |
| req_h | input | 7 | Requested height |
| disp_w | input | 12 | Display width in pixels |
| disp_h | input | 12 | Display height in lines |
| interlaced | input | 1 | Halve the vertical extent and position |
| frame_done | input | 1 | End-of-frame pulse that commits pending state |
| pix_valid | input | 1 | Background pixel valid |
| pix_x | input | 12 | Background pixel column |
| pix_y | input | 12 | Background pixel line |
| bg_rgb | input | 24 | Background pixel colour |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Output pixel colour |
| cur_on | output | 1 | Cursor currently shown |
| act_pos | output | 32 | Active {screen y, screen x} |
| act_size | output | 32 | Active {visible h, visible w} |

## Verification
The status outputs respond one edge after a request. `cur_on` drops on the edge that takes an invisible request. An accepted request becomes visible only on the edge that sees `frame_done`. The bench therefore drives every input on a falling edge. It samples the status at the next falling edge and checks that nothing has moved before the frame-done pulse. A pixel result is due on the second rising edge after the pixel is presented. Each pixel is held, and its output is read at the falling edge after that second rising edge. The expected colour comes from the bench's own image formula and its own clip arithmetic.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;
  localparam int MAX_DIM  = 64;
  localparam int HALF_DIM = 32;
  localparam int DIM_W    = 7;

  // exchange byte 0 and byte 2 of a 32-bit pixel word
  function automatic logic [31:0] swap_rb(input logic [31:0] p);
    return {p[31:24], p[7:0], p[15:8], p[23:16]};
  endfunction
endpackage

// File: rtl/hwcur_clip.sv
module hwcur_clip #(
  parameter int CW = 12,
  parameter int DW = hwcur_pkg::DIM_W
) (
  input  logic signed [CW-1:0] req_x,
  input  logic signed [CW-1:0] req_y,
  input  logic [DW-1:0]        req_w,
  input  logic [DW-1:0]        req_h,
  input  logic [CW-1:0]        disp_w,
  input  logic [CW-1:0]        disp_h,
  input  logic                 interlaced,
  input  logic                 img_present,
  output logic                 visible,
  output logic [CW-1:0]        scr_x,
  output logic [CW-1:0]        scr_y,
  output logic [CW-1:0]        off_x,
  output logic [CW-1:0]        off_y,
  output logic [DW-1:0]        vis_w,
  output logic [DW-1:0]        vis_h
);
  localparam int EW = CW + 2;
  localparam int RW = 2 * CW + DW;

  function automatic logic [RW-1:0] axis(input logic signed [CW-1:0] p,
                                         input logic [DW-1:0] len,
                                         input logic [CW-1:0] lim);
    logic signed [EW-1:0] ps, ls, ms, s, o, v;
    ps = {{2{p[CW-1]}}, p};
    ls = {{(EW-DW){1'b0}}, len};
    ms = {2'b00, lim};
    if (ps < 0) begin
      o = -ps;
      s = '0;
      v = (o >= ls) ? '0 : ls - o;
    end else if (ps + ls > ms) begin
      o = '0;
      s = ps;
      v = (ms > ps) ? ms - ps : '0;
    end else begin
      o = '0;
      s = ps;
      v = ls;
    end
    return {s[CW-1:0], o[CW-1:0], v[DW-1:0]};
  endfunction

  logic [RW-1:0] xr, yr;
  logic [CW-1:0] sy_raw;
  logic [DW-1:0] vh_raw;
  logic          size_ok;

  always_comb begin
    xr      = axis(req_x, req_w, disp_w);
    yr      = axis(req_y, req_h, disp_h);
    scr_x   = xr[RW-1 -: CW];
    off_x   = xr[DW +: CW];
    vis_w   = xr[DW-1:0];
    sy_raw  = yr[RW-1 -: CW];
    off_y   = yr[DW +: CW];
    vh_raw  = yr[DW-1:0];
    scr_y   = interlaced ? (sy_raw >> 1) : sy_raw;
    vis_h   = interlaced ? (vh_raw >> 1) : vh_raw;
    size_ok = (req_w != '0) && (req_h != '0) &&
              (int'(req_w) <= hwcur_pkg::MAX_DIM) && (int'(req_h) <= hwcur_pkg::MAX_DIM) &&
              !((int'(req_w) > hwcur_pkg::HALF_DIM) && (int'(req_h) > hwcur_pkg::HALF_DIM));
    visible = size_ok && img_present && (vis_w != '0) && (vis_h != '0);
  end
endmodule

// File: rtl/hwcur_ram.sv
module hwcur_ram #(
  parameter int AW      = 11,
  parameter int BANK_AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_restart,
  input  logic [31:0]   wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [31:0]   rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [31:0]   mem [DEPTH];
  logic [AW-1:0] ptr, waddr;

  assign waddr = wr_restart ? '0 : ptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= hwcur_pkg::swap_rb(wr_data);
    rd_data <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)        ptr <= '0;
    else if (wr_en) ptr <= waddr + 1'b1;
    else if (wr_restart) ptr <= '0;
  end

  AST_BANK_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_restart && (ptr[BANK_AW-1:0] == '1)) |=>
      (ptr[BANK_AW-1:0] == '0) && (ptr[AW-1:BANK_AW] == $past(ptr[AW-1:BANK_AW]) + 1'b1)); // R2
  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_restart) |=> (ptr == 1)); // R2
endmodule

// File: rtl/hwcur_mix.sv
module hwcur_mix #(
  parameter int CW = 12,
  parameter int DW = hwcur_pkg::DIM_W,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [CW-1:0] scr_x,
  input  logic [CW-1:0] scr_y,
  input  logic [CW-1:0] off_x,
  input  logic [CW-1:0] off_y,
  input  logic [DW-1:0] vis_w,
  input  logic [DW-1:0] vis_h,
  input  logic [DW-1:0] stride,
  input  logic          pix_valid,
  input  logic [CW-1:0] pix_x,
  input  logic [CW-1:0] pix_y,
  input  logic [23:0]   bg_rgb,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  output logic          out_valid,
  output logic [23:0]   out_rgb
);
  localparam int LW = CW + DW;

  logic [CW:0]   x_end, y_end;
  logic          in_x, in_y, hit;
  logic [CW-1:0] row, col;
  logic [LW-1:0] lin;
  logic          hit1, valid1;
  logic [23:0]   bg1;

  always_comb begin
    x_end   = {1'b0, scr_x} + {{(CW+1-DW){1'b0}}, vis_w};
    y_end   = {1'b0, scr_y} + {{(CW+1-DW){1'b0}}, vis_h};
    in_x    = (pix_x >= scr_x) && ({1'b0, pix_x} < x_end);
    in_y    = (pix_y >= scr_y) && ({1'b0, pix_y} < y_end);
    hit     = en && pix_valid && in_x && in_y;
    row     = pix_y - scr_y + off_y;
    col     = pix_x - scr_x + off_x;
    lin     = {{DW{1'b0}}, row} * {{CW{1'b0}}, stride} + {{DW{1'b0}}, col};
    rd_addr = lin[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit1 <= 1'b0; valid1 <= 1'b0; bg1 <= '0;
      out_valid <= 1'b0; out_rgb <= '0;
    end else begin
      hit1   <= hit;
      valid1 <= pix_valid;
      bg1    <= bg_rgb;
      out_valid <= valid1;
      out_rgb   <= (hit1 && rd_data[31:24] != 8'h00) ?
                   {rd_data[7:0], rd_data[15:8], rd_data[23:16]} : bg1;
    end
  end

  AST_ADDR_IN_IMAGE: assert property (@(posedge clk) disable iff (rst)
    hit |-> (lin < LW'(hwcur_pkg::MAX_DIM * hwcur_pkg::HALF_DIM))); // R9
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (valid1 && !hit1) |=> (out_rgb == $past(bg1))); // R8
  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    valid1 |=> out_valid); // R8
endmodule

// File: rtl/hwcur_top.sv
module hwcur_top #(
  parameter int CW      = 12,
  parameter int DW      = hwcur_pkg::DIM_W,
  parameter int AW      = 11,
  parameter int BANK_AW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 px_wr_en,
  input  logic                 px_wr_restart,
  input  logic [31:0]          px_wr_data,
  input  logic                 img_present,
  input  logic                 upd_strobe,
  input  logic signed [CW-1:0] req_x,
  input  logic signed [CW-1:0] req_y,
  input  logic [DW-1:0]        req_w,
  input  logic [DW-1:0]        req_h,
  input  logic [CW-1:0]        disp_w,
  input  logic [CW-1:0]        disp_h,
  input  logic                 interlaced,
  input  logic                 frame_done,
  input  logic                 pix_valid,
  input  logic [CW-1:0]        pix_x,
  input  logic [CW-1:0]        pix_y,
  input  logic [23:0]          bg_rgb,
  output logic                 out_valid,
  output logic [23:0]          out_rgb,
  output logic                 cur_on,
  output logic [31:0]          act_pos,
  output logic [31:0]          act_size
);
  localparam int PADC = 16 - CW;
  localparam int PADD = 16 - DW;

  logic          c_vis;
  logic [CW-1:0] c_sx, c_sy, c_ox, c_oy;
  logic [DW-1:0] c_vw, c_vh;

  logic          pend;
  logic [CW-1:0] sh_sx, sh_sy, sh_ox, sh_oy, a_sx, a_sy, a_ox, a_oy;
  logic [DW-1:0] sh_vw, sh_vh, sh_st, a_vw, a_vh, a_st;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data;

  hwcur_clip #(.CW(CW), .DW(DW)) clip_i (
    .req_x(req_x), .req_y(req_y), .req_w(req_w), .req_h(req_h),
    .disp_w(disp_w), .disp_h(disp_h), .interlaced(interlaced),
    .img_present(img_present), .visible(c_vis),
    .scr_x(c_sx), .scr_y(c_sy), .off_x(c_ox), .off_y(c_oy),
    .vis_w(c_vw), .vis_h(c_vh));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0; cur_on <= 1'b0;
      sh_sx <= '0; sh_sy <= '0; sh_ox <= '0; sh_oy <= '0;
      sh_vw <= '0; sh_vh <= '0; sh_st <= '0;
      a_sx <= '0; a_sy <= '0; a_ox <= '0; a_oy <= '0;
      a_vw <= '0; a_vh <= '0; a_st <= '0;
    end else begin
      if (frame_done && pend) begin
        a_sx <= sh_sx; a_sy <= sh_sy; a_ox <= sh_ox; a_oy <= sh_oy;
        a_vw <= sh_vw; a_vh <= sh_vh; a_st <= sh_st;
        cur_on <= 1'b1;
        pend   <= 1'b0;
      end
      if (upd_strobe) begin
        if (c_vis) begin
          sh_sx <= c_sx; sh_sy <= c_sy; sh_ox <= c_ox; sh_oy <= c_oy;
          sh_vw <= c_vw; sh_vh <= c_vh; sh_st <= req_w;
          pend  <= 1'b1;
        end else begin
          cur_on <= 1'b0;
          pend   <= 1'b0;
        end
      end
    end
  end

  assign act_pos  = {{PADC{1'b0}}, a_sy, {PADC{1'b0}}, a_sx};
  assign act_size = {{PADD{1'b0}}, a_vh, {PADD{1'b0}}, a_vw};

  hwcur_ram #(.AW(AW), .BANK_AW(BANK_AW)) ram_i (
    .clk(clk), .rst(rst), .wr_en(px_wr_en), .wr_restart(px_wr_restart),
    .wr_data(px_wr_data), .rd_addr(rd_addr), .rd_data(rd_data));

  hwcur_mix #(.CW(CW), .DW(DW), .AW(AW)) mix_i (
    .clk(clk), .rst(rst), .en(cur_on),
    .scr_x(a_sx), .scr_y(a_sy), .off_x(a_ox), .off_y(a_oy),
    .vis_w(a_vw), .vis_h(a_vh), .stride(a_st),
    .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .bg_rgb(bg_rgb),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .out_valid(out_valid), .out_rgb(out_rgb));

  AST_HOLD_UNTIL_FRAME: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> ($stable(act_pos) && $stable(act_size))); // R7
  AST_NO_RISE_WITHOUT_FRAME: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> !$rose(cur_on)); // R7
  AST_KILL_NOW: assert property (@(posedge clk) disable iff (rst)
    (upd_strobe && !c_vis) |=> !cur_on); // R6
  AST_ON_NONZERO: assert property (@(posedge clk) disable iff (rst)
    cur_on |-> (a_vw != '0) && (a_vh != '0)); // R6
  AST_SIZE_CAP: assert property (@(posedge clk) disable iff (rst)
    cur_on |-> (int'(a_st) <= hwcur_pkg::MAX_DIM) &&
               !((int'(a_st) > hwcur_pkg::HALF_DIM) && (int'(a_vh) > hwcur_pkg::HALF_DIM))); // R1
endmodule

// File: tb/hwcur_top_tb.sv
`timescale 1ns/1ps
module hwcur_top_tb_top;
  localparam int CW = 12;
  localparam int DW = 7;
  localparam int DISPW = 100;
  localparam int DISPH = 60;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, px_wr_en, px_wr_restart, img_present, upd_strobe, interlaced, frame_done, pix_valid;
  logic [31:0] px_wr_data;
  logic signed [CW-1:0] req_x, req_y;
  logic [DW-1:0] req_w, req_h;
  logic [CW-1:0] disp_w, disp_h, pix_x, pix_y;
  logic [23:0] bg_rgb, out_rgb;
  logic out_valid, cur_on;
  logic [31:0] act_pos, act_size;

  hwcur_top dut_i (
    .clk(clk), .rst(rst), .px_wr_en(px_wr_en), .px_wr_restart(px_wr_restart),
    .px_wr_data(px_wr_data), .img_present(img_present), .upd_strobe(upd_strobe),
    .req_x(req_x), .req_y(req_y), .req_w(req_w), .req_h(req_h),
    .disp_w(disp_w), .disp_h(disp_h), .interlaced(interlaced), .frame_done(frame_done),
    .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y), .bg_rgb(bg_rgb),
    .out_valid(out_valid), .out_rgb(out_rgb), .cur_on(cur_on),
    .act_pos(act_pos), .act_size(act_size));

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pix_word(input int i);
    logic [7:0] a, r, g, b;
    a = (i % 5 == 0) ? 8'h00 : (8'h80 | 8'(i));
    r = 8'(i * 3);
    g = 8'hC0 ^ 8'(i);
    b = 8'(8'h10 + i);
    return {a, r, g, b};
  endfunction

  function automatic logic [23:0] bg_of(input int px, input int py);
    return {8'(px * 7), 8'(py * 11), 8'h5A};
  endfunction

  function automatic void exp_clip(input int x, input int y, input int w, input int h,
                                   input bit il, input bit img, output bit vis,
                                   output int sx, output int sy, output int vw, output int vh);
    bit ok;
    ok = (w >= 1) && (h >= 1) && (w <= 64) && (h <= 64) && !((w > 32) && (h > 32));
    if (x < 0) begin sx = 0; vw = (-x >= w) ? 0 : w + x; end
    else if (x + w > DISPW) begin sx = x; vw = (DISPW > x) ? DISPW - x : 0; end
    else begin sx = x; vw = w; end
    if (y < 0) begin sy = 0; vh = (-y >= h) ? 0 : h + y; end
    else if (y + h > DISPH) begin sy = y; vh = (DISPH > y) ? DISPH - y : 0; end
    else begin sy = y; vh = h; end
    if (il) begin vh = vh / 2; sy = sy / 2; end
    vis = ok && img && (vw > 0) && (vh > 0);
  endfunction

  // called at a falling edge; returns at the falling edge after the taking edge
  task automatic do_update(input int x, input int y, input int w, input int h, input bit il);
    req_x = 12'(x); req_y = 12'(y); req_w = 7'(w); req_h = 7'(h);
    interlaced = il; upd_strobe = 1'b1;
    @(negedge clk);
    upd_strobe = 1'b0;
  endtask

  task automatic do_commit();
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
  endtask

  task automatic load_img(input int n);
    for (int i = 0; i < n; i++) begin
      px_wr_en = 1'b1; px_wr_restart = (i == 0); px_wr_data = pix_word(i);
      @(negedge clk);
    end
    px_wr_en = 1'b0; px_wr_restart = 1'b0;
  endtask

  // present one pixel, sample two rising edges later
  task automatic probe(input int px, input int py, output logic [23:0] res);
    pix_valid = 1'b1; pix_x = 12'(px); pix_y = 12'(py); bg_rgb = bg_of(px, py);
    @(negedge clk);
    @(negedge clk);
    res = out_rgb;
  endtask

  task automatic sweep_pix(input int x0, input int x1, input int y0, input int y1,
                           input int sx, input int sy, input int vw, input int vh,
                           input int ox, input int oy, input int st, input string tag);
    logic [23:0] res, exp;
    for (int py = y0; py <= y1; py++) begin
      for (int px = x0; px <= x1; px++) begin
        probe(px, py, res);
        exp = bg_of(px, py);
        if (px >= sx && px < sx + vw && py >= sy && py < sy + vh) begin
          logic [31:0] w;
          w = pix_word((py - sy + oy) * st + (px - sx + ox));
          if (w[31:24] != 8'h00) exp = w[23:0];
        end
        chk(res == exp, tag, 64'(res), 64'(exp));
      end
    end
    pix_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      nchk++;
      $display("FAIL watchdog R8 actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int psx, psy, pvw, pvh, sx, sy, vw, vh;
    bit pon, vis;
    logic [23:0] res;
    int wl[7] = '{1, 8, 64, 32, 64, 33, 65};
    int hl[7] = '{1, 4, 32, 64, 33, 33, 1};

    rst = 1'b1; px_wr_en = 1'b0; px_wr_restart = 1'b0; px_wr_data = '0;
    img_present = 1'b1; upd_strobe = 1'b0; interlaced = 1'b0; frame_done = 1'b0;
    pix_valid = 1'b0; pix_x = '0; pix_y = '0; bg_rgb = '0;
    req_x = '0; req_y = '0; req_w = '0; req_h = '0;
    disp_w = 12'(DISPW); disp_h = 12'(DISPH);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    chk(cur_on == 1'b0, "R7 reset cur_on", 64'(cur_on), 0);
    chk(act_pos == 0 && act_size == 0, "R7 reset act", {act_pos, act_size}, 0);
    chk(out_valid == 1'b0, "R8 reset out_valid", 64'(out_valid), 0);

    // clipping / size / interlace sweep
    pon = 1'b0; psx = 0; psy = 0; pvw = 0; pvh = 0;
    for (int k = 0; k < 7; k++) begin
      for (int il = 0; il < 2; il++) begin
        for (int x = -70; x <= 110; x += 7) begin
          for (int y = -40; y <= 70; y += 9) begin
            string tag;
            exp_clip(x, y, wl[k], hl[k], il[0], 1'b1, vis, sx, sy, vw, vh);
            tag = (wl[k] > 32 || hl[k] > 32) ? "R1" : (il != 0) ? "R5" :
                  (x < 0 || y < 0) ? "R3" : "R4";
            do_update(x, y, wl[k], hl[k], il[0]);
            if (vis) begin
              chk(cur_on == pon && act_pos == {16'(psy), 16'(psx)} &&
                  act_size == {16'(pvh), 16'(pvw)}, "R7 held before frame_done",
                  {cur_on, act_pos[30:0], act_size}, {pon, 15'(psy), 16'(psx), 16'(pvh), 16'(pvw)});
            end else begin
              chk(cur_on == 1'b0, "R6 immediate off", 64'(cur_on), 0);
            end
            do_commit();
            if (vis) begin
              chk(cur_on == 1'b1 && act_pos == {16'(sy), 16'(sx)} &&
                  act_size == {16'(vh), 16'(vw)}, tag,
                  {cur_on, act_pos[30:0], act_size}, {1'b1, 15'(sy), 16'(sx), 16'(vh), 16'(vw)});
              pon = 1'b1; psx = sx; psy = sy; pvw = vw; pvh = vh;
            end else begin
              chk(cur_on == 1'b0, "R6 stays off after frame_done", 64'(cur_on), 0);
              pon = 1'b0;
            end
          end
        end
      end
    end

    // no image loaded
    img_present = 1'b0;
    do_update(5, 5, 8, 4, 1'b0);
    chk(cur_on == 1'b0, "R6 no image", 64'(cur_on), 0);
    do_commit();
    chk(cur_on == 1'b0, "R6 no image after frame_done", 64'(cur_on), 0);
    img_present = 1'b1;

    // overlay with left/top clip and bitmap offset
    load_img(32);
    do_update(-3, -1, 8, 4, 1'b0);
    do_commit();
    sweep_pix(0, 15, 0, 7, 0, 0, 5, 3, 3, 1, 8, "R3 R8 R9 overlay left/top");

    // overlay with right/bottom clip
    do_update(95, 58, 8, 4, 1'b0);
    do_commit();
    sweep_pix(88, 99, 54, 59, 95, 58, 5, 2, 0, 0, 8, "R4 R8 overlay right/bottom");

    // image crossing into the second bank
    load_img(320);
    do_update(10, 5, 32, 10, 1'b0);
    do_commit();
    sweep_pix(8, 43, 11, 15, 10, 5, 32, 10, 0, 0, 32, "R2 R9 second bank");

    // invalid pixel and cursor-off pass-through
    pix_valid = 1'b0; pix_x = 12'd12; pix_y = 12'd6; bg_rgb = bg_of(12, 6);
    @(negedge clk); @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid low", 64'(out_valid), 0);
    do_update(10, 5, 0, 4, 1'b0);
    chk(cur_on == 1'b0, "R6 zero width", 64'(cur_on), 0);
    probe(12, 6, res);
    chk(res == bg_of(12, 6) && out_valid, "R8 pass-through when off", 64'(res), 64'(bg_of(12, 6)));
    pix_valid = 1'b0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule